// File: doc/BRIEF.md
# Boot Source and Remap Selector

This block chooses which memory region is visible at address zero. On the first clock edge after reset is released it samples the boot strap inputs. These are a boot pin, a software boot level, a bit that picks between pin and software level, a secondary boot bit and a boot-lock bit. From them it derives a default memory-mode code. The code drives a select output toward the address decoder.

Software can replace the memory-mode code at any time through a single-register write port. The same register holds a bank-swap bit that goes to a dual-bank flash controller. That bit exchanges the mapping of the two banks and chooses which bank is aliased at address zero. A read port returns the register contents at all times.

Top module: `boot_remap_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode field and the bank bit clear to 0. `zero_region_sel` reads 000 and `cfg_rdata` reads all zeros.
- R2: The boot inputs are sampled exactly once, on the first rising edge where `rst_n` is high. From that edge on, the mode field holds the computed default and the bank bit holds 0.
- R3: The effective boot level is `boot_sw_level` when `boot_src_pin` is 0. It is `boot_pin` when `boot_src_pin` is 1.
- R4: An effective boot level of 0 gives the default mode 000, which is main flash.
- R5: An effective boot level of 1 gives 001 (system flash) when `boot_second` is 1. It gives 011 (SRAM1) when `boot_second` is 0.
- R6: When `boot_lock` is 1 at the sampling edge, the default mode is 000, whatever the other boot inputs are.
- R7: Changes on any boot input after the sampling edge have no effect on the outputs until the next reset.
- R8: After sampling, a write with `cfg_we` high loads `cfg_wdata[2:0]` into the mode field and `cfg_wdata[8]` into the bank bit. The new values appear on the outputs after that clock edge.
- R9: The mode codes are 000 main flash, 001 system flash, 010 external bank 1, 011 SRAM1 and 100 quad-SPI. `zero_region_sel` follows these codes. The reserved codes 101, 110 and 111 drive `zero_region_sel` to 000.
- R10: `cfg_rdata[2:0]` returns the stored mode field, including a reserved code if one was written. `cfg_rdata[8]` returns the bank bit, and every other bit reads 0 whatever was written.
- R11: A write presented on the sampling edge is discarded. The sampled default wins.
- R12: `flash_bank_swap` always equals the stored bank bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_pin | input | 1 | External boot strap level |
| boot_sw_level | input | 1 | Software-programmed boot level |
| boot_src_pin | input | 1 | 1: take level from pin, 0: from software level |
| boot_second | input | 1 | Secondary boot bit (1 system flash, 0 SRAM1) |
| boot_lock | input | 1 | Forces boot from main flash |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | DATA_W (32) | Register write data |
| cfg_rdata | output | DATA_W (32) | Register read data |
| zero_region_sel | output | 3 | Region select for address zero |
| flash_bank_swap | output | 1 | Flash bank swap control |

## Verification
The bench uses the default parameters: a 32-bit register, a 3-bit mode field and the bank bit at position 8. The mode field therefore has three reserved codes, and the write data has many upper bits that must be masked. Random writes cover the reserved codes and the masked bits. The bench walks all 32 combinations of the boot inputs through fresh resets. With them it checks the lock priority and the pin-versus-software selection against a bench model.

// File: rtl/boot_remap_pkg.sv
// Shared codes and the boot default rule for the remap selector.
// Assumes a 3-bit mode field; codes above RGN_LAST are reserved.
package boot_remap_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        RGN_MAIN  = 3'd0,
        RGN_SYS   = 3'd1,
        RGN_EXT1  = 3'd2,
        RGN_SRAM  = 3'd3,
        RGN_QSPI  = 3'd4
    } region_e;

    localparam logic [MODE_W-1:0] RGN_LAST = 3'd4;

    // Default mode from strap inputs: lock first, then level, then secondary bit.
    function automatic logic [MODE_W-1:0] boot_default(
        input logic pin, input logic sw_lvl, input logic src_pin,
        input logic second, input logic lock);
        logic lvl;
        lvl = src_pin ? pin : sw_lvl;
        if (lock)       return RGN_MAIN;
        else if (!lvl)  return RGN_MAIN;
        else if (second) return RGN_SYS;
        else            return RGN_SRAM;
    endfunction
endpackage

// File: rtl/boot_sampler.sv
// Samples the boot straps once after reset and emits a one-cycle capture
// pulse with the derived default mode. Assumes synchronous active-low reset.
module boot_sampler
    import boot_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic              boot_sw_level,
    input  logic              boot_src_pin,
    input  logic              boot_second,
    input  logic              boot_lock,
    output logic              cap_pulse,
    output logic [MODE_W-1:0] dflt_mode
);
    logic sampled_q;

    // Remembers that the straps were taken since the last reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sampled_q <= 1'b0;
        else        sampled_q <= 1'b1;
    end

    // Pulse during the first cycle with reset released.
    assign cap_pulse = rst_n & ~sampled_q;
    assign dflt_mode = boot_default(boot_pin, boot_sw_level, boot_src_pin,
                                    boot_second, boot_lock);

    // R2: the sampled flag never drops while out of reset.
    assert_sample_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sampled_q |=> sampled_q);
    // R6: lock always yields main flash as default.
    assert_lock_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_lock |-> dflt_mode == RGN_MAIN);
endmodule

// File: rtl/remap_reg.sv
// Holds the remap register image (mode field plus bank bit). Loads the
// sampled default on the capture pulse, otherwise accepts software writes.
// Assumes BANK_POS lies above the mode field and inside DATA_W.
module remap_reg
    import boot_remap_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BANK_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pulse,
    input  logic [MODE_W-1:0] dflt_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] img,
    output logic [MODE_W-1:0] mode,
    output logic              bank
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << BANK_POS) | DATA_W'((1 << MODE_W) - 1);

    logic [DATA_W-1:0] img_q;

    // Register image update: reset, capture, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)          img_q <= '0;
        else if (cap_pulse)  img_q <= DATA_W'(dflt_mode);
        else if (wr_en)      img_q <= wr_data & KEEP_MASK;
    end

    assign img  = img_q;
    assign mode = img_q[MODE_W-1:0];
    assign bank = img_q[BANK_POS];

    // R2 and R11: capture loads the default, bank cleared, writes discarded.
    assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (mode == $past(dflt_mode)) && !bank);
    // R8: a write outside capture lands in the field.
    assert_write_land_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_pulse) |=> (mode == $past(wr_data[MODE_W-1:0]))
                                  && (bank == $past(wr_data[BANK_POS])));
    // R10: unused bits remain zero.
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> (img & ~KEEP_MASK) == '0);
    // R7: without capture or write the image holds.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_pulse && !wr_en) |=> $stable(img));
endmodule

// File: rtl/zero_decode.sv
// Maps the stored mode code to the region select; reserved codes fall
// back to main flash. Purely combinational.
module zero_decode
    import boot_remap_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic [MODE_W-1:0] sel
);
    // Pass legal codes, fold reserved ones onto main flash.
    always_comb begin
        if (mode <= RGN_LAST) sel = mode;
        else                  sel = RGN_MAIN;
    end

    // R9: the select never carries a reserved code.
    always_comb begin
        assert_sel_legal_R9: assert (sel <= RGN_LAST);
    end
endmodule

// File: rtl/boot_remap_sel.sv
// Top of the boot source and remap selector. Samples straps after reset,
// holds the software-visible remap register and drives the zero-region
// select and flash bank swap. Synchronous active-low reset.
module boot_remap_sel
    import boot_remap_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BANK_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic              boot_sw_level,
    input  logic              boot_src_pin,
    input  logic              boot_second,
    input  logic              boot_lock,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [2:0]        zero_region_sel,
    output logic              flash_bank_swap
);
    logic              cap_pulse;
    logic [MODE_W-1:0] dflt_mode;
    logic [MODE_W-1:0] mode;
    logic              bank;

    boot_sampler u_sampler (
        .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
        .boot_sw_level(boot_sw_level), .boot_src_pin(boot_src_pin),
        .boot_second(boot_second), .boot_lock(boot_lock),
        .cap_pulse(cap_pulse), .dflt_mode(dflt_mode)
    );

    remap_reg #(.DATA_W(DATA_W), .BANK_POS(BANK_POS)) u_reg (
        .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse), .dflt_mode(dflt_mode),
        .wr_en(cfg_we), .wr_data(cfg_wdata), .img(cfg_rdata),
        .mode(mode), .bank(bank)
    );

    zero_decode u_dec (.mode(mode), .sel(zero_region_sel));

    assign flash_bank_swap = bank;

    // R1: in reset the outputs return to their cleared state next cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == '0) && (zero_region_sel == 3'd0) && !flash_bank_swap);
    // R12: bank swap mirrors the read-back bank bit.
    assert_bank_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flash_bank_swap == cfg_rdata[BANK_POS]);
endmodule

// File: tb/tb_boot_remap_sel.sv
module tb_boot_remap_sel;
    localparam int DW = 32;
    localparam int BP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_pin = 0, boot_sw_level = 0, boot_src_pin = 0, boot_second = 0, boot_lock = 0;
    logic cfg_we = 0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic [2:0] zero_region_sel;
    logic flash_bank_swap;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2:0] exp_mode;
    logic exp_bank;

    always #5 clk = ~clk;

    boot_remap_sel #(.DATA_W(DW), .BANK_POS(BP)) dut (
        .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .boot_sw_level(boot_sw_level),
        .boot_src_pin(boot_src_pin), .boot_second(boot_second), .boot_lock(boot_lock),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .zero_region_sel(zero_region_sel), .flash_bank_swap(flash_bank_swap)
    );

    function automatic logic [2:0] model_default(logic p, logic s, logic src, logic sec, logic lk);
        logic lvl;
        lvl = src ? p : s;
        if (lk) return 3'd0;
        if (!lvl) return 3'd0;
        return sec ? 3'd1 : 3'd3;
    endfunction

    function automatic logic [2:0] model_sel(logic [2:0] m);
        return (m > 3'd4) ? 3'd0 : m;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        logic [DW-1:0] rd;
        rd = '0;
        rd[2:0] = exp_mode;
        rd[BP] = exp_bank;
        check({req, " rdata"}, cfg_rdata, rd);
        check({req, " sel"}, {29'd0, zero_region_sel}, {29'd0, model_sel(exp_mode)});
        check({req, " swap"}, {31'd0, flash_bank_swap}, {31'd0, exp_bank});
    endtask

    // Reset with given straps, optional write on the sampling edge (R11).
    task automatic boot(logic [4:0] s, bit wr_on_cap);
        @(negedge clk);
        rst_n = 0;
        {boot_pin, boot_sw_level, boot_src_pin, boot_second, boot_lock} = s;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        exp_mode = 3'd0; exp_bank = 0;
        check_state("R1");
        rst_n = 1;
        if (wr_on_cap) begin cfg_we = 1; cfg_wdata = 32'h0000_0104; end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
        exp_mode = model_default(s[4], s[3], s[2], s[1], s[0]);
        exp_bank = 0;
        check_state(wr_on_cap ? "R11" : "R2/R3/R4/R5/R6");
    endtask

    task automatic wr(logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
        exp_mode = d[2:0]; exp_bank = d[BP];
        check_state(d[2:0] > 3'd4 ? "R9/R10" : "R8/R10/R12");
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Directed corners: lock priority, source select, secondary bit.
        boot(5'b11111, 0); // R6 lock overrides
        boot(5'b10110, 0); // R3 pin, R5 system flash
        boot(5'b01110, 0); // R3 pin low -> R4
        boot(5'b01010, 0); // R3 software level, R5 system
        boot(5'b01000, 0); // R5 SRAM1
        boot(5'b10000, 0); // R4 software level 0
        boot(5'b10110, 1); // R11
        // R7: strap changes after sampling ignored
        @(negedge clk);
        {boot_pin, boot_sw_level, boot_src_pin, boot_second, boot_lock} = 5'b01001;
        repeat (3) @(negedge clk);
        check_state("R7");
        // R9: every code
        for (int c = 0; c < 8; c++) wr(DW'(c) | (DW'(c & 1) << BP));
        wr(32'hFFFF_FFFF); // R10 masking
        // All strap combinations
        for (int s = 0; s < 32; s++) boot(5'(s), 0);
        // Random writes and boots
        for (int i = 0; i < 200; i++) begin
            if (($urandom % 8) == 0) boot(5'($urandom), 0);
            else wr($urandom);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule